// File: doc/BRIEF.md
# Shared Register Write Arbiter

This block merges two writers onto one register write port of a video controller: a host CPU that writes over its system bus, and a coprocessor that issues register writes on its own schedule. The controller port accepts at most one write per cycle. When both writers target the controller in the same cycle, the coprocessor wins. The CPU write is caught in a one-entry buffer and replayed on a later cycle.

The controller has busy windows, such as fetch-heavy display lines, during which it ignores register writes. In such a window the block holds the coprocessor off by dropping its ready signal. CPU writes that land in a busy window are parked in the same buffer. The buffer keeps only the newest write, so a read-modify-write pair that collides leaves only its second value. Writes to the CPU stack page are never parked or delayed. CPU writes outside the controller's register window are ignored.

Top module: `shared_reg_write_arbiter`

## Requirements
- R1: After synchronous active-high reset, `buf_pending` is 0 and, with `vc_busy` low, `cop_ready` is 1.
- R2: A CPU write to 0xD000–0xD3FF with `vc_busy` low, nothing pending and no coprocessor request appears on the controller port in the same cycle. `vc_addr` is CPU address bits [9:0] and `vc_wdata` is the CPU data. The buffer stays empty.
- R3: A CPU write outside 0xD000–0xD3FF produces no controller write and leaves `buf_pending` unchanged.
- R4: A CPU write to 0x0100–0x01FF is never captured. This holds in a busy window and during a coprocessor write. `buf_pending` stays 0.
- R5: When a coprocessor write is accepted in the same cycle as a CPU window write, the port carries the coprocessor address and data. `buf_pending` is 1 from the next cycle.
- R6: While `buf_pending` is 1 and `vc_busy` is low, the port replays the buffered address and data and `cop_ready` is 0. `buf_pending` is 0 afterwards unless a new CPU window write arrives in that cycle.
- R7: A CPU window write captured while a write is already pending replaces it. Only the newest address and data are replayed, exactly once.
- R8: While `vc_busy` is 1, `vc_we` and `cop_ready` are 0. A CPU window write in that cycle is captured. A held coprocessor request goes out on the first non-busy cycle with nothing pending.
- R9: A coprocessor write (`cop_req` high while `cop_ready` is 1) drives `vc_addr` with `cop_addr` and `vc_wdata` with `cop_wdata` in the same cycle. `cop_ready` is 1 whenever `vc_busy` is low and `buf_pending` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| cop_req | input | 1 | Coprocessor write request |
| cop_addr | input | 10 | Coprocessor register offset |
| cop_wdata | input | 8 | Coprocessor write data |
| vc_busy | input | 1 | Controller cannot take register writes this cycle |
| vc_we | output | 1 | Controller write strobe, one cycle per write |
| vc_addr | output | 10 | Controller register offset |
| vc_wdata | output | 8 | Controller write data |
| cop_ready | output | 1 | Coprocessor write accepted when high with `cop_req` |
| buf_pending | output | 1 | A CPU write waits in the replay buffer |

## Verification
The only internal state is the pending flag and the parked address and data. A fault in any of them shows at the ports within one cycle of the first free cycle. A stuck or stale flag makes `cop_ready` drop, or a replay strobe appear, when none is due. A wrong parked value shows as a mismatched replay. A failed overwrite shows as two replays or an old value. The scoreboard matches every strobe on the controller port against an ordered list of expected writes, so a missing, extra or reordered write is caught on the cycle it occurs.

// File: rtl/rwa_pkg.sv
package rwa_pkg;
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_COP  = 2'd1,
        SRC_CPU  = 2'd2,
        SRC_BUF  = 2'd3
    } port_src_e;
endpackage

// File: rtl/rwa_addr_decode.sv
module rwa_addr_decode #(
    parameter int          CPU_AW     = 16,
    parameter int          WIN_AW     = 10,
    parameter logic [15:0] WIN_BASE   = 16'hD000,
    parameter int          STACK_AW   = 8,
    parameter logic [15:0] STACK_BASE = 16'h0100
) (
    input  logic              we,
    input  logic [CPU_AW-1:0] addr,
    output logic              win_hit
);
    logic in_win;
    logic in_stack;

    always_comb begin
        in_win   = (addr[CPU_AW-1:WIN_AW] == WIN_BASE[CPU_AW-1:WIN_AW]);
        in_stack = (addr[CPU_AW-1:STACK_AW] == STACK_BASE[CPU_AW-1:STACK_AW]);
        // stack-page traffic is never treated as a controller write
        win_hit  = we && in_win && !in_stack;
    end
endmodule

// File: rtl/rwa_arbiter.sv
module rwa_arbiter
    import rwa_pkg::*;
(
    input  logic      busy,
    input  logic      pend_q,
    input  logic      cop_req,
    input  logic      cpu_hit,
    output port_src_e src,
    output logic      capture,
    output logic      release_buf,
    output logic      cop_ready
);
    always_comb begin
        src         = SRC_NONE;
        capture     = 1'b0;
        release_buf = 1'b0;
        cop_ready   = !busy && !pend_q;
        if (busy) begin
            capture = cpu_hit;
        end else if (pend_q) begin
            src         = SRC_BUF;
            release_buf = 1'b1;
            capture     = cpu_hit;
        end else if (cop_req) begin
            src     = SRC_COP;
            capture = cpu_hit;
        end else if (cpu_hit) begin
            src = SRC_CPU;
        end
    end
endmodule

// File: rtl/rwa_capture_buf.sv
module rwa_capture_buf #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic          release_buf,
    input  logic [AW-1:0] cap_addr,
    input  logic [DW-1:0] cap_data,
    output logic          pend,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data
);
    typedef struct packed {
        logic          pend;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } buf_state_t;

    buf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (capture) begin
            st_d.pend = 1'b1;
            st_d.addr = cap_addr;
            st_d.data = cap_data;
        end else if (release_buf) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;
    assign addr = st_q.addr;
    assign data = st_q.data;
endmodule

// File: rtl/shared_reg_write_arbiter.sv
module shared_reg_write_arbiter
    import rwa_pkg::*;
#(
    parameter int          CPU_AW     = 16,
    parameter int          REG_AW     = 10,
    parameter int          DW         = 8,
    parameter logic [15:0] WIN_BASE   = 16'hD000,
    parameter logic [15:0] STACK_BASE = 16'h0100,
    parameter int          STACK_AW   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_we,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    input  logic              cop_req,
    input  logic [REG_AW-1:0] cop_addr,
    input  logic [DW-1:0]     cop_wdata,
    input  logic              vc_busy,
    output logic              vc_we,
    output logic [REG_AW-1:0] vc_addr,
    output logic [DW-1:0]     vc_wdata,
    output logic              cop_ready,
    output logic              buf_pending
);
    logic              cpu_hit;
    port_src_e         src;
    logic              capture;
    logic              release_buf;
    logic [REG_AW-1:0] buf_addr;
    logic [DW-1:0]     buf_data;

    rwa_addr_decode #(
        .CPU_AW    (CPU_AW),
        .WIN_AW    (REG_AW),
        .WIN_BASE  (WIN_BASE),
        .STACK_AW  (STACK_AW),
        .STACK_BASE(STACK_BASE)
    ) u_dec (
        .we     (cpu_we),
        .addr   (cpu_addr),
        .win_hit(cpu_hit)
    );

    rwa_arbiter u_arb (
        .busy       (vc_busy),
        .pend_q     (buf_pending),
        .cop_req    (cop_req),
        .cpu_hit    (cpu_hit),
        .src        (src),
        .capture    (capture),
        .release_buf(release_buf),
        .cop_ready  (cop_ready)
    );

    rwa_capture_buf #(
        .AW(REG_AW),
        .DW(DW)
    ) u_buf (
        .clk        (clk),
        .rst        (rst),
        .capture    (capture),
        .release_buf(release_buf),
        .cap_addr   (cpu_addr[REG_AW-1:0]),
        .cap_data   (cpu_wdata),
        .pend       (buf_pending),
        .addr       (buf_addr),
        .data       (buf_data)
    );

    always_comb begin
        vc_we    = (src != SRC_NONE);
        vc_addr  = '0;
        vc_wdata = '0;
        case (src)
            SRC_COP: begin
                vc_addr  = cop_addr;
                vc_wdata = cop_wdata;
            end
            SRC_CPU: begin
                vc_addr  = cpu_addr[REG_AW-1:0];
                vc_wdata = cpu_wdata;
            end
            SRC_BUF: begin
                vc_addr  = buf_addr;
                vc_wdata = buf_data;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rwa_checker.sv
module rwa_checker #(
    parameter int CPU_AW = 16,
    parameter int REG_AW = 10,
    parameter int DW     = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_we,
    input logic [CPU_AW-1:0] cpu_addr,
    input logic [DW-1:0]     cpu_wdata,
    input logic              cop_req,
    input logic [REG_AW-1:0] cop_addr,
    input logic [DW-1:0]     cop_wdata,
    input logic              vc_busy,
    input logic              vc_we,
    input logic [REG_AW-1:0] vc_addr,
    input logic [DW-1:0]     vc_wdata,
    input logic              cop_ready,
    input logic              buf_pending
);
    logic win_w;
    logic stack_w;
    assign win_w   = cpu_we && (cpu_addr[CPU_AW-1:REG_AW] == 6'b110100);
    assign stack_w = cpu_we && (cpu_addr[CPU_AW-1:8] == 8'h01);

    p_busy_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        vc_busy |-> (!vc_we && !cop_ready));

    p_replay_r6: assert property (@(posedge clk) disable iff (rst)
        (buf_pending && !vc_busy) |-> (vc_we && !cop_ready));

    p_replay_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (buf_pending && !vc_busy && !win_w) |=> !buf_pending);

    p_collide_capture_r5: assert property (@(posedge clk) disable iff (rst)
        (cop_req && cop_ready && win_w) |=> buf_pending);

    p_cop_path_r9: assert property (@(posedge clk) disable iff (rst)
        (cop_req && cop_ready) |-> (vc_we && vc_addr == cop_addr && vc_wdata == cop_wdata));

    p_stack_bypass_r4: assert property (@(posedge clk) disable iff (rst)
        (!buf_pending && stack_w) |=> !buf_pending);

    p_pass_same_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        (win_w && !vc_busy && !buf_pending && !cop_req)
        |-> (vc_we && vc_addr == cpu_addr[REG_AW-1:0] && vc_wdata == cpu_wdata));
endmodule

bind shared_reg_write_arbiter rwa_checker #(
    .CPU_AW(CPU_AW),
    .REG_AW(REG_AW),
    .DW    (DW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cop_req    (cop_req),
    .cop_addr   (cop_addr),
    .cop_wdata  (cop_wdata),
    .vc_busy    (vc_busy),
    .vc_we      (vc_we),
    .vc_addr    (vc_addr),
    .vc_wdata   (vc_wdata),
    .cop_ready  (cop_ready),
    .buf_pending(buf_pending)
);

// File: tb/shared_reg_write_arbiter_tb.sv
module shared_reg_write_arbiter_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cop_req = 1'b0;
    logic [9:0]  cop_addr = '0;
    logic [7:0]  cop_wdata = '0;
    logic        vc_busy = 1'b0;
    logic        vc_we;
    logic [9:0]  vc_addr;
    logic [7:0]  vc_wdata;
    logic        cop_ready;
    logic        buf_pending;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic [17:0] expq[$];
    string cur_tag = "R1";

    always #2 clk = ~clk;

    shared_reg_write_arbiter u_dut (
        .clk(clk), .rst(rst),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cop_req(cop_req), .cop_addr(cop_addr), .cop_wdata(cop_wdata),
        .vc_busy(vc_busy),
        .vc_we(vc_we), .vc_addr(vc_addr), .vc_wdata(vc_wdata),
        .cop_ready(cop_ready), .buf_pending(buf_pending)
    );

    // monitor: every port strobe must match the head of the expected queue
    always @(negedge clk) begin
        if (!rst && !done && vc_we) begin
            tests++;
            if (expq.size() == 0) begin
                fails++;
                $display("FAIL %s: unexpected write addr=%h data=%h, expected none",
                         cur_tag, vc_addr, vc_wdata);
            end else begin
                logic [17:0] e;
                e = expq.pop_front();
                if (e != {vc_addr, vc_wdata}) begin
                    fails++;
                    $display("FAIL %s: write addr=%h data=%h, expected addr=%h data=%h",
                             cur_tag, vc_addr, vc_wdata, e[17:8], e[7:0]);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: %s=%b, expected %b", tag, what, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus, queues the expected write
    task automatic cyc(input string tag,
                       input logic cw, input logic [15:0] ca, input logic [7:0] cd,
                       input logic pr, input logic [9:0] pa, input logic [7:0] pd,
                       input logic bz, input logic ew, input logic [9:0] ea,
                       input logic [7:0] ed, input logic erdy, input logic epend_after);
        cur_tag   = tag;
        cpu_we    = cw; cpu_addr = ca; cpu_wdata = cd;
        cop_req   = pr; cop_addr = pa; cop_wdata = pd;
        vc_busy   = bz;
        if (ew) expq.push_back({ea, ed});
        @(negedge clk);
        chk(tag, cop_ready, erdy, "cop_ready");
        @(posedge clk);
        #1;
        chk(tag, buf_pending, epend_after, "buf_pending");
        if (expq.size() != 0) begin
            tests++; fails++;
            $display("FAIL %s: %0d expected writes missing, expected 0", tag, expq.size());
            expq.delete();
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            fails++; tests++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1", buf_pending, 1'b0, "buf_pending after reset");
        chk("R1", cop_ready, 1'b1, "cop_ready after reset");
        @(posedge clk); #1;

        // R2: straight-through CPU writes, incl. both window edges
        cyc("R2", 1, 16'hD020, 8'h0E, 0, 0, 0, 0, 1, 10'h020, 8'h0E, 1, 0);
        cyc("R2", 1, 16'hD3FF, 8'hA5, 0, 0, 0, 0, 1, 10'h3FF, 8'hA5, 1, 0);
        cyc("R2", 1, 16'hD000, 8'h5A, 0, 0, 0, 0, 1, 10'h000, 8'h5A, 1, 0);
        // R3: outside window is ignored
        cyc("R3", 1, 16'h4000, 8'h77, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        cyc("R3", 1, 16'hD400, 8'h77, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        cyc("R3", 1, 16'hCFFF, 8'h77, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        // R9: coprocessor write
        cyc("R9", 0, 0, 0, 1, 10'h011, 8'h1B, 0, 1, 10'h011, 8'h1B, 1, 0);
        // R5 collision, then R6 replay on idle cycle
        cyc("R5", 1, 16'hD019, 8'h01, 1, 10'h018, 8'h14, 0, 1, 10'h018, 8'h14, 1, 1);
        cyc("R6", 0, 0, 0, 0, 0, 0, 0, 1, 10'h019, 8'h01, 0, 0);
        cyc("R6", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        // R6: replay stalls a waiting coprocessor request for one cycle
        cyc("R5", 1, 16'hD021, 8'h06, 1, 10'h020, 8'h00, 0, 1, 10'h020, 8'h00, 1, 1);
        cyc("R6", 0, 0, 0, 1, 10'h022, 8'h33, 0, 1, 10'h021, 8'h06, 0, 0);
        cyc("R6", 0, 0, 0, 1, 10'h022, 8'h33, 0, 1, 10'h022, 8'h33, 1, 0);
        // R8 + R7: two captures in a busy window, only the second replayed
        cyc("R8", 1, 16'hD019, 8'h01, 0, 0, 0, 1, 0, 0, 0, 0, 1);
        cyc("R7", 1, 16'hD019, 8'h00, 0, 0, 0, 1, 0, 0, 0, 0, 1);
        cyc("R7", 0, 0, 0, 0, 0, 0, 0, 1, 10'h019, 8'h00, 0, 0);
        cyc("R7", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        // R7: capture during a replay cycle replaces the entry
        cyc("R5", 1, 16'hD030, 8'h10, 1, 10'h031, 8'h20, 0, 1, 10'h031, 8'h20, 1, 1);
        cyc("R7", 1, 16'hD032, 8'h30, 0, 0, 0, 0, 1, 10'h030, 8'h10, 0, 1);
        cyc("R7", 0, 0, 0, 0, 0, 0, 0, 1, 10'h032, 8'h30, 0, 0);
        // R8: coprocessor held through busy, released afterwards
        cyc("R8", 0, 0, 0, 1, 10'h0AA, 8'hC3, 1, 0, 0, 0, 0, 0);
        cyc("R8", 0, 0, 0, 1, 10'h0AA, 8'hC3, 1, 0, 0, 0, 0, 0);
        cyc("R8", 0, 0, 0, 1, 10'h0AA, 8'hC3, 1, 0, 0, 0, 0, 0);
        cyc("R8", 0, 0, 0, 1, 10'h0AA, 8'hC3, 0, 1, 10'h0AA, 8'hC3, 1, 0);
        // R4: stack page never captured
        cyc("R4", 1, 16'h01FF, 8'h12, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        cyc("R4", 1, 16'h0100, 8'h34, 1, 10'h005, 8'h56, 0, 1, 10'h005, 8'h56, 1, 0);
        cyc("R4", 1, 16'h01FE, 8'h78, 0, 0, 0, 0, 0, 0, 0, 1, 0);

        // R1: reset clears a pending entry
        cyc("R1", 1, 16'hD040, 8'h99, 0, 0, 0, 1, 0, 0, 0, 0, 1);
        rst = 1'b1;
        cpu_we = 0; cop_req = 0; vc_busy = 0;
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        chk("R1", buf_pending, 1'b0, "buf_pending after mid-run reset");
        chk("R1", vc_we, 1'b0, "vc_we after mid-run reset");
        @(posedge clk); #1;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule